// File: doc/BRIEF.md
# Segmented paging address translator

This block turns a 14-bit virtual address into a 14-bit physical address in two steps. The top bits pick a segment. That segment's descriptor gives two values: where its private page table starts inside a shared page-table store, and how many pages the segment holds. The page field is first checked against that page count. Only if it passes is it added to the table start, and the page-table entry at that sum is read. A valid entry provides a frame number. The frame number placed above the untouched byte offset is the physical address.

A translation starts when `req` is seen while the block is idle. It then steps through a short fixed sequence with one cycle per step: segment lookup, page-table lookup, and result. A page past the end of the segment is reported as a limit fault straight after the segment step, and the page-table step is skipped. An entry with its valid bit clear is reported as a page fault. The descriptor table and the page-table store are loaded through two simple write ports. Each write takes effect at a clock edge.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `busy`, `done`, `fault_limit`, `fault_page` and `pa` are all zero. Every segment has a page count of 0, so any request ends in a limit fault. Every page-table entry is invalid.
- R2: Virtual address layout: `va[13:12]` is the segment, `va[11:8]` is the page within the segment, and `va[7:0]` is the byte offset. The physical address is `{frame[5:0], offset[7:0]}`.
- R3: A request whose page is in range and whose entry is valid gives `done`=1 exactly 3 clock edges after the edge that accepted it. In that cycle `pa` = `{frame, va[7:0]}` and both fault outputs are low.
- R4: If page ≥ the segment's page count, `fault_limit`=1 and `pa`=0, with `done` 2 edges after acceptance. Page = count−1 is still in range.
- R5: The page-table entry read is at index (segment table start + page) mod 64. Segments whose table starts differ read different entries for the same page number.
- R6: An in-range page whose entry has the valid bit clear gives `fault_page`=1, `fault_limit`=0 and `pa`=0, with `done` 3 edges after acceptance.
- R7: `busy` rises on the accepting edge and stays high through the `done` cycle, then falls. `req` is ignored while `busy` is high, and the result belongs to the accepted address.
- R8: `done` is a single-cycle pulse. While `done` is low, `pa` and both fault outputs are zero.
- R9: A page-table write that lands on the same edge that captures the lookup does not change the current result; the lookup returns the old entry. The next translation sees the new entry.
- R10: A descriptor write sets the table start (6 bits) and page count (5 bits, 0 to 16) for the segment `seg_wr_idx`. It applies to requests accepted after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a translation (taken only when idle) |
| va | input | 14 | Virtual address |
| seg_wr_en | input | 1 | Descriptor write strobe |
| seg_wr_idx | input | 2 | Segment being written |
| seg_wr_base | input | 6 | Page-table start for that segment |
| seg_wr_len | input | 5 | Page count for that segment |
| pt_wr_en | input | 1 | Page-table write strobe |
| pt_wr_addr | input | 6 | Page-table entry index |
| pt_wr_valid | input | 1 | Valid bit to store |
| pt_wr_frame | input | 6 | Frame number to store |
| busy | output | 1 | Translation in progress |
| done | output | 1 | Result pulse |
| pa | output | 14 | Physical address (valid on a successful done) |
| fault_limit | output | 1 | Page beyond the segment's page count |
| fault_page | output | 1 | Page-table entry invalid |

## Verification
A page-table write and the page-table read of a running translation can fall on the same clock edge. The bench forces this by accepting a request and then, two edges later, writing a new frame into exactly the entry being read. That write is timed so it is captured on the lookup edge. The result must carry the old frame, and an immediate repeat translation must carry the new one. A second overlap, a held `req` during the busy window, is judged by requiring the result of the first address and a return to idle with no second acceptance.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int SEG_W    = 2;
    localparam int PAGE_W   = 4;
    localparam int OFS_W    = 8;
    localparam int FRAME_W  = 6;
    localparam int PT_DEPTH = 64;

    localparam int VA_W  = SEG_W + PAGE_W + OFS_W;
    localparam int PA_W  = FRAME_W + OFS_W;
    localparam int NSEG  = 1 << SEG_W;
    localparam int PT_AW = $clog2(PT_DEPTH);
    localparam int LEN_W = PAGE_W + 1;

    typedef struct packed {
        logic [PT_AW-1:0] base;
        logic [LEN_W-1:0] len;
    } seg_ent_t;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_PT   = 2'd2,
        ST_DONE = 2'd3
    } walk_state_e;

    function automatic logic [SEG_W-1:0] va_seg(input logic [VA_W-1:0] a);
        return a[VA_W-1 -: SEG_W];
    endfunction

    function automatic logic [PAGE_W-1:0] va_page(input logic [VA_W-1:0] a);
        return a[OFS_W +: PAGE_W];
    endfunction

    function automatic logic [OFS_W-1:0] va_ofs(input logic [VA_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction

    function automatic logic [PT_AW-1:0] pt_index(input logic [PT_AW-1:0] b,
                                                  input logic [PAGE_W-1:0] p);
        return b + PT_AW'(p);
    endfunction
endpackage

// File: rtl/sp_seg_table.sv
module sp_seg_table
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_ent_t         wr_ent,
    input  logic [SEG_W-1:0] rd_idx,
    output seg_ent_t         rd_ent
);
    seg_ent_t ents [NSEG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSEG; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = ents[rd_idx];
endmodule

// File: rtl/sp_page_table.sv
module sp_page_table
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PT_AW-1:0] wr_addr,
    input  pte_t             wr_pte,
    input  logic [PT_AW-1:0] rd_addr,
    output pte_t             rd_pte
);
    pte_t mem [PT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PT_DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_pte;
        end
    end

    assign rd_pte = mem[rd_addr];
endmodule

// File: rtl/sp_walk_fsm.sv
module sp_walk_fsm
    import sp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [VA_W-1:0]  va,
    output logic [SEG_W-1:0] seg_idx,
    input  seg_ent_t         seg_ent,
    output logic [PT_AW-1:0] pt_addr,
    input  pte_t             pte,
    output logic             busy,
    output logic             done,
    output logic [PA_W-1:0]  pa,
    output logic             fault_limit,
    output logic             fault_page
);
    walk_state_e          state;
    logic [VA_W-1:0]      va_q;
    logic [PT_AW-1:0]     pt_addr_q;
    logic [FRAME_W-1:0]   frame_q;
    logic                 lim_q;
    logic                 pgf_q;
    logic                 in_range;

    assign seg_idx  = va_seg(va_q);
    assign pt_addr  = pt_addr_q;
    assign in_range = {1'b0, va_page(va_q)} < seg_ent.len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            pt_addr_q <= '0;
            frame_q   <= '0;
            lim_q     <= 1'b0;
            pgf_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req) begin
                    va_q  <= va;
                    lim_q <= 1'b0;
                    pgf_q <= 1'b0;
                    state <= ST_SEG;
                end
                ST_SEG: if (!in_range) begin
                    lim_q <= 1'b1;
                    state <= ST_DONE;
                end else begin
                    pt_addr_q <= pt_index(seg_ent.base, va_page(va_q));
                    state     <= ST_PT;
                end
                ST_PT: begin
                    if (pte.valid) frame_q <= pte.frame;
                    else           pgf_q   <= 1'b1;
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_DONE);
    assign fault_limit = done && lim_q;
    assign fault_page  = done && pgf_q;
    assign pa          = (done && !lim_q && !pgf_q) ? {frame_q, va_ofs(va_q)} : '0;

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (req && !busy) |=> busy);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (pa == '0 && !fault_limit && !fault_page));
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_limit, fault_page}));
    p_limit_skip_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEG && !in_range) |=> fault_limit);
    p_page_after_walk_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PT && !pte.valid) |=> fault_page);
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
    import sp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [VA_W-1:0]    va,
    input  logic               seg_wr_en,
    input  logic [SEG_W-1:0]   seg_wr_idx,
    input  logic [PT_AW-1:0]   seg_wr_base,
    input  logic [LEN_W-1:0]   seg_wr_len,
    input  logic               pt_wr_en,
    input  logic [PT_AW-1:0]   pt_wr_addr,
    input  logic               pt_wr_valid,
    input  logic [FRAME_W-1:0] pt_wr_frame,
    output logic               busy,
    output logic               done,
    output logic [PA_W-1:0]    pa,
    output logic               fault_limit,
    output logic               fault_page
);
    logic [SEG_W-1:0] seg_idx;
    seg_ent_t         seg_ent;
    logic [PT_AW-1:0] pt_addr;
    pte_t             pte;
    seg_ent_t         seg_wdata;
    pte_t             pt_wdata;

    assign seg_wdata = '{base: seg_wr_base, len: seg_wr_len};
    assign pt_wdata  = '{valid: pt_wr_valid, frame: pt_wr_frame};

    sp_seg_table u_seg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (seg_wr_en),
        .wr_idx (seg_wr_idx),
        .wr_ent (seg_wdata),
        .rd_idx (seg_idx),
        .rd_ent (seg_ent)
    );

    sp_page_table u_pt (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pt_wr_en),
        .wr_addr (pt_wr_addr),
        .wr_pte  (pt_wdata),
        .rd_addr (pt_addr),
        .rd_pte  (pte)
    );

    sp_walk_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .va          (va),
        .seg_idx     (seg_idx),
        .seg_ent     (seg_ent),
        .pt_addr     (pt_addr),
        .pte         (pte),
        .busy        (busy),
        .done        (done),
        .pa          (pa),
        .fault_limit (fault_limit),
        .fault_page  (fault_page)
    );
endmodule

// File: tb/seg_page_xlate_test.sv
module seg_page_xlate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [13:0] va = '0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_idx = '0;
    logic [5:0]  seg_wr_base = '0;
    logic [4:0]  seg_wr_len = '0;
    logic        pt_wr_en = 1'b0;
    logic [5:0]  pt_wr_addr = '0;
    logic        pt_wr_valid = 1'b0;
    logic [5:0]  pt_wr_frame = '0;
    logic        busy, done, fault_limit, fault_page;
    logic [13:0] pa;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    seg_page_xlate uut (
        .clk(clk), .rst(rst), .req(req), .va(va),
        .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
        .seg_wr_base(seg_wr_base), .seg_wr_len(seg_wr_len),
        .pt_wr_en(pt_wr_en), .pt_wr_addr(pt_wr_addr),
        .pt_wr_valid(pt_wr_valid), .pt_wr_frame(pt_wr_frame),
        .busy(busy), .done(done), .pa(pa),
        .fault_limit(fault_limit), .fault_page(fault_page)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] mkva(input int s, input int p, input int o);
        return {2'(s), 4'(p), 8'(o)};
    endfunction

    task automatic wr_seg(input int idx, input int base, input int len);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_idx = 2'(idx);
        seg_wr_base = 6'(base); seg_wr_len = 5'(len);
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    task automatic wr_pt(input int addr, input bit v, input int frame);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_addr = 6'(addr);
        pt_wr_valid = v; pt_wr_frame = 6'(frame);
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    // Drive one request, wait for done, check result, latency and return to idle.
    task automatic translate(input string tag, input logic [13:0] a,
                             input int exp_pa, input bit exp_l, input bit exp_p,
                             input int exp_lat);
        int n;
        @(negedge clk);
        req = 1'b1; va = a;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " R7 busy after accept"}, busy, 1);
        n = 1;
        while (!done && n < 8) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " latency"}, n, exp_lat);
        chk({tag, " pa"}, pa, exp_pa);
        chk({tag, " fault_limit"}, fault_limit, exp_l);
        chk({tag, " fault_page"}, fault_page, exp_p);
        @(negedge clk);
        chk({tag, " R8 done pulse"}, done, 0);
        chk({tag, " R7 idle after done"}, busy, 0);
        chk({tag, " R8 pa quiet"}, pa, 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 pa", pa, 0);
        chk("R1 faults", {fault_limit, fault_page}, 0);
        translate("R1 empty seg", mkva(0, 0, 8'h10), 0, 1, 0, 2);
    endtask

    task automatic t_basic;
        wr_seg(1, 8, 4);                 // R10
        wr_pt(10, 1, 6'h2A);
        translate("R3 R2 basic", mkva(1, 2, 8'h5C), {6'h2A, 8'h5C}, 0, 0, 3);
        wr_pt(8, 1, 6'h01);
        translate("R3 page0 ofs max", mkva(1, 0, 8'hFF), {6'h01, 8'hFF}, 0, 0, 3);
    endtask

    task automatic t_limit;
        translate("R4 page=len", mkva(1, 4, 8'h33), 0, 1, 0, 2);
        translate("R4 page high", mkva(1, 15, 8'h33), 0, 1, 0, 2);
        translate("R6 invalid pte", mkva(1, 3, 8'h44), 0, 0, 1, 3);
        wr_pt(11, 1, 6'h15);
        translate("R4 page=len-1", mkva(1, 3, 8'h44), {6'h15, 8'h44}, 0, 0, 3);
    endtask

    task automatic t_regions;
        wr_seg(2, 40, 16);
        wr_pt(42, 1, 6'h11);
        translate("R5 distinct region", mkva(2, 2, 8'h5C), {6'h11, 8'h5C}, 0, 0, 3);
        wr_seg(3, 60, 16);
        wr_pt(1, 1, 6'h3F);
        translate("R5 wrap", mkva(3, 5, 8'h07), {6'h3F, 8'h07}, 0, 0, 3);
        wr_seg(1, 8, 0);
        translate("R10 len rewritten", mkva(1, 2, 8'h00), 0, 1, 0, 2);
        wr_seg(1, 8, 4);
    endtask

    task automatic t_busy_ignore;
        int n;
        @(negedge clk);
        req = 1'b1; va = mkva(1, 2, 8'hA1);
        @(negedge clk);
        va = mkva(2, 2, 8'hB2);          // held request while busy
        n = 1;
        while (!done && n < 8) begin
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        chk("R7 held req pa", pa, {6'h2A, 8'hA1});
        chk("R7 held req latency", n, 3);
        @(negedge clk);
        chk("R7 no reaccept", busy, 0);
        @(negedge clk);
        chk("R7 still idle", busy, 0);
    endtask

    task automatic t_collide;
        wr_pt(8, 1, 6'h05);
        @(negedge clk);
        req = 1'b1; va = mkva(1, 0, 8'h66);
        @(negedge clk);                  // accepted, segment step
        req = 1'b0;
        @(negedge clk);                  // page-table step
        pt_wr_en = 1'b1; pt_wr_addr = 6'd8; pt_wr_valid = 1'b1; pt_wr_frame = 6'h07;
        @(negedge clk);                  // write and lookup shared an edge
        pt_wr_en = 1'b0;
        chk("R9 collide done", done, 1);
        chk("R9 old entry used", pa, {6'h05, 8'h66});
        translate("R9 new entry", mkva(1, 0, 8'h66), {6'h07, 8'h66}, 0, 0, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_limit();
        t_regions();
        t_busy_ignore();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule